// File: doc/BRIEF.md
# Variable Fine Phase Step Controller

This block is the control half of a clock manager's adjustable phase shifter. It holds a signed phase setting and changes it by one unit per accepted request. Requests arrive on a dedicated adjustment clock as an enable plus a direction select. Once a request is taken the unit is busy for a fixed, parameterised number of adjustment-clock cycles. It then emits a one-cycle completion pulse, and only after that pulse will it take another request.

The setting is clamped to a symmetric range of plus or minus 255 units, where one unit is 1/512 of the input clock period. A request that would cross a limit still completes normally, but the setting does not move and a clip flag pulses alongside the completion pulse. A second output carries the same setting as a tap count for a downstream delay line. That tap count lies in the range 0 to 511, so a negative shift is expressed as a positive delay of the equivalent length within one input period.

Polarity parameters let the enable, the direction select and the adjustment clock each be used true or inverted.

Top module: `phase_step_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), phase_set takes INIT_PHASE (default 0) and busy, step_done and sat_hit are all low. Once reset is released, delay_taps reflects that setting.
- R2: A request is accepted on an adjustment-clock rising edge at which the enable is active and busy is low. busy is high from the edge that follows acceptance onward.
- R3: step_done is high for exactly one cycle. It is set on the DONE_LAT-th rising edge after the accepting edge (default DONE_LAT = 3).
- R4: With direction high (true polarity), phase_set rises by one. With direction low, it falls by one. The direction is taken at the accepting edge, and phase_set changes only on the edge that sets step_done.
- R5: phase_set never leaves the range -255 to +255. A step that would pass a limit leaves phase_set unchanged, and sat_hit is high in the same cycle as step_done. sat_hit is low at all other times.
- R6: An enable that is active while busy is high is ignored. This includes the edge at which step_done is set. Such an enable produces no extra completion pulse and no extra step.
- R7: delay_taps equals phase_set when phase_set is zero or positive, and 512 plus phase_set when it is negative.
- R8: When EN_INV, DIR_INV or CLK_INV is set, the corresponding input is inverted before use (low enable is active, low select increments, falling clock edge is active). Outputs are otherwise identical.
- R9: busy falls on the same edge that sets step_done, so step_done and busy are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ps_clk_in | input | 1 | Adjustment clock, polarity selected by CLK_INV |
| rst_n | input | 1 | Asynchronous reset, active low |
| ps_en_in | input | 1 | Step request, polarity selected by EN_INV |
| ps_dir_in | input | 1 | Step direction (increment when active), polarity selected by DIR_INV |
| step_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High from acceptance until completion |
| sat_hit | output | 1 | Pulses with step_done when the step was clipped at a limit |
| phase_set | output | 9 | Signed phase setting in 1/512 period units |
| delay_taps | output | 9 | Equivalent delay, 0 to 511 units of 1/512 period |

## Verification
Two coincidences are provoked. The first is a request landing on the edge at which the completion pulse is produced. The bench holds the enable active, with the direction flipped, through every busy cycle including the completion edge. It then drops the enable before the next edge, and the scoreboard reports any second completion pulse, or a busy still high one cycle later, as a failure. The second coincidence is completion together with clipping. The setting is driven to each limit and pushed past it, and each completion there must carry sat_hit with an unchanged setting, while every completion elsewhere must carry sat_hit low.

// File: rtl/phs_pkg.sv
package phs_pkg;

  typedef struct packed {
    logic en;
    logic up;
  } ps_req_t;

  // next setting after one step, held at the limit
  function automatic int sat_step(int p, bit up, int lim);
    if (up) return (p >= lim) ? lim : p + 1;
    return (p <= -lim) ? -lim : p - 1;
  endfunction

  // true when a step in the given direction would leave the range
  function automatic bit is_clipped(int p, bit up, int lim);
    return up ? (p >= lim) : (p <= -lim);
  endfunction

  // signed setting folded into one period of taps
  function automatic int wrap_delay(int p, int span);
    return (p < 0) ? p + span : p;
  endfunction

endpackage

// File: rtl/phs_input_cond.sv
module phs_input_cond
  import phs_pkg::*;
#(
  parameter bit EN_INV  = 1'b0,
  parameter bit DIR_INV = 1'b0
) (
  input  logic    en_raw,
  input  logic    dir_raw,
  output ps_req_t req
);

  generate
    if (EN_INV) begin : g_en_inv
      assign req.en = ~en_raw;
    end else begin : g_en_true
      assign req.en = en_raw;
    end

    if (DIR_INV) begin : g_dir_inv
      assign req.up = ~dir_raw;
    end else begin : g_dir_true
      assign req.up = dir_raw;
    end
  endgenerate

endmodule

// File: rtl/phs_step_timer.sv
module phs_step_timer
  import phs_pkg::*;
#(
  parameter int DONE_LAT = 3,
  parameter int CNT_W    = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ps_req_t req,
  output logic    accept,
  output logic    finish,
  output logic    step_up,
  output logic    busy,
  output logic    done
);

  logic [CNT_W-1:0] cnt;

  assign accept = req.en & ~busy;
  assign finish = busy & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      step_up <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(DONE_LAT - 1);
        step_up <= req.up;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/phs_accum.sv
module phs_accum
  import phs_pkg::*;
#(
  parameter int PHASE_LIM  = 255,
  parameter int INIT_PHASE = 0,
  parameter int PH_W       = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   finish,
  input  logic                   step_up,
  output logic signed [PH_W-1:0] setting,
  output logic                   clip
);

  int  cur_i;
  int  nxt_i;
  logic clip_now;

  always_comb begin
    cur_i    = int'(setting);
    nxt_i    = sat_step(cur_i, step_up, PHASE_LIM);
    clip_now = is_clipped(cur_i, step_up, PHASE_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setting <= PH_W'(INIT_PHASE);
      clip    <= 1'b0;
    end else begin
      clip <= finish & clip_now;
      if (finish) setting <= PH_W'(nxt_i);
    end
  end

endmodule

// File: rtl/phs_delay_map.sv
module phs_delay_map
  import phs_pkg::*;
#(
  parameter int PH_W  = 9,
  parameter int SPAN  = 512,
  parameter int DLY_W = 9
) (
  input  logic signed [PH_W-1:0] setting,
  output logic [DLY_W-1:0]       taps
);

  always_comb begin
    taps = DLY_W'(wrap_delay(int'(setting), SPAN));
  end

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import phs_pkg::*;
#(
  parameter int PHASE_LIM  = 255,
  parameter int INIT_PHASE = 0,
  parameter int DONE_LAT   = 3,
  parameter bit EN_INV     = 1'b0,
  parameter bit DIR_INV    = 1'b0,
  parameter bit CLK_INV    = 1'b0
) (
  input  logic              ps_clk_in,
  input  logic              rst_n,
  input  logic              ps_en_in,
  input  logic              ps_dir_in,
  output logic              step_done,
  output logic              busy,
  output logic              sat_hit,
  output logic signed [8:0] phase_set,
  output logic [8:0]        delay_taps
);

  localparam int PH_W  = $clog2(PHASE_LIM + 1) + 1;
  localparam int SPAN  = 2 * (PHASE_LIM + 1);
  localparam int DLY_W = $clog2(SPAN);
  localparam int CNT_W = (DONE_LAT < 2) ? 1 : $clog2(DONE_LAT);

  logic    core_clk;
  ps_req_t req;
  logic    req_en;
  logic    accept;
  logic    finish;
  logic    step_up;
  logic signed [PH_W-1:0] setting;
  logic [DLY_W-1:0]       taps;

  generate
    if (CLK_INV) begin : g_clk_inv
      assign core_clk = ~ps_clk_in;
    end else begin : g_clk_true
      assign core_clk = ps_clk_in;
    end
  endgenerate

  phs_input_cond #(.EN_INV(EN_INV), .DIR_INV(DIR_INV)) u_cond (
    .en_raw (ps_en_in),
    .dir_raw(ps_dir_in),
    .req    (req)
  );

  assign req_en = req.en;

  phs_step_timer #(.DONE_LAT(DONE_LAT), .CNT_W(CNT_W)) u_timer (
    .clk    (core_clk),
    .rst_n  (rst_n),
    .req    (req),
    .accept (accept),
    .finish (finish),
    .step_up(step_up),
    .busy   (busy),
    .done   (step_done)
  );

  phs_accum #(.PHASE_LIM(PHASE_LIM), .INIT_PHASE(INIT_PHASE), .PH_W(PH_W)) u_accum (
    .clk    (core_clk),
    .rst_n  (rst_n),
    .finish (finish),
    .step_up(step_up),
    .setting(setting),
    .clip   (sat_hit)
  );

  phs_delay_map #(.PH_W(PH_W), .SPAN(SPAN), .DLY_W(DLY_W)) u_map (
    .setting(setting),
    .taps   (taps)
  );

  assign phase_set  = 9'(setting);
  assign delay_taps = 9'(taps);

endmodule

// File: rtl/phs_checker.sv
module phs_checker #(
  parameter int LIM  = 255,
  parameter int PH_W = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_en,
  input logic                   accept,
  input logic                   finish,
  input logic                   busy,
  input logic                   done,
  input logic                   ovf,
  input logic signed [PH_W-1:0] setting
);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_setting_moves_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(setting) |-> done);

  assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(setting) <= LIM) && (int'(setting) >= -LIM));

  assert_no_overflow_without_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> done);

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish && req_en) |=> (busy && !done));

  assert_busy_fall_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind phase_step_ctrl phs_checker #(.LIM(PHASE_LIM), .PH_W(PH_W)) u_chk (
  .clk    (core_clk),
  .rst_n  (rst_n),
  .req_en (req_en),
  .accept (accept),
  .finish (finish),
  .busy   (busy),
  .done   (step_done),
  .ovf    (sat_hit),
  .setting(setting)
);

// File: tb/tb_phase_step_ctrl.sv
`timescale 1ns/1ps
module tb_phase_step_ctrl;
  localparam int LIM  = 255;
  localparam int LAT  = 3;
  localparam int SPAN = 512;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, dir = 1'b0;
  always #10 clk = ~clk;

  logic done_a, busy_a, ovf_a, done_b, busy_b, ovf_b;
  logic signed [8:0] set_a, set_b;
  logic [8:0] dly_a, dly_b;

  phase_step_ctrl #(.DONE_LAT(LAT)) dut (
    .ps_clk_in(clk), .rst_n(rst_n), .ps_en_in(en), .ps_dir_in(dir),
    .step_done(done_a), .busy(busy_a), .sat_hit(ovf_a),
    .phase_set(set_a), .delay_taps(dly_a));

  // all three polarities inverted, driven with inverted stimulus (R8)
  phase_step_ctrl #(.DONE_LAT(LAT), .EN_INV(1'b1), .DIR_INV(1'b1), .CLK_INV(1'b1)) dut_inv (
    .ps_clk_in(~clk), .rst_n(rst_n), .ps_en_in(~en), .ps_dir_in(~dir),
    .step_done(done_b), .busy(busy_b), .sat_hit(ovf_b),
    .phase_set(set_b), .delay_taps(dly_b));

  typedef struct {int p; bit ovf; int cyc;} exp_t;
  exp_t sbq[$];

  int cyc = 0;
  int checks = 0, fails = 0;
  int model_p = 0;
  bit ended = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_taps(int p);
    if (p >= 0) return p;
    return SPAN + p;
  endfunction

  // driver: one request, optionally with enable held through busy (R6)
  task automatic step(bit up, bit noise);
    exp_t e;
    @(negedge clk);
    while (busy_a) @(negedge clk);
    en = 1'b1;
    dir = up;
    e.ovf = up ? (model_p >= LIM) : (model_p <= -LIM);
    if (!e.ovf) model_p = up ? model_p + 1 : model_p - 1;
    e.p = model_p;
    e.cyc = cyc + 1 + LAT;
    sbq.push_back(e);
    @(negedge clk);
    check("R2", int'(busy_a), 1, "busy after accept");
    if (noise) begin
      dir = ~up;
      repeat (LAT) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check("R6", int'(busy_a), 0, "busy after ignored enables");
      check("R6", sbq.size(), 0, "pending completions");
    end else begin
      en = 1'b0;
    end
  endtask

  // monitor: pops expected completions as they appear
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && !ended) begin
      if (sbq.size() != 0 && sbq[0].cyc < cyc) begin
        e = sbq.pop_front();
        checks++; fails++;
        $display("FAIL R3 missing done actual=%0d expected=%0d", cyc, e.cyc);
      end
      if (done_a) begin
        if (sbq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6 unexpected done actual=1 expected=0");
        end else begin
          e = sbq.pop_front();
          check("R3", cyc, e.cyc, "done cycle");
          check("R4", int'(set_a), e.p, "setting");
          check("R5", int'(ovf_a), int'(e.ovf), "clip flag");
          check("R7", int'(dly_a), exp_taps(e.p), "delay taps");
          check("R9", int'(busy_a), 0, "busy with done");
          check("R8", int'(set_b), e.p, "inverted setting");
          check("R8", int'(done_b), 1, "inverted done");
          check("R8", int'(ovf_b), int'(e.ovf), "inverted clip");
          check("R8", int'(dly_b), exp_taps(e.p), "inverted taps");
        end
      end else if (ovf_a) begin
        check("R5", int'(ovf_a), 0, "clip without done");
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(set_a), 0, "reset setting");
    check("R1", int'(busy_a), 0, "reset busy");
    check("R1", int'(done_a), 0, "reset done");
    check("R1", int'(ovf_a), 0, "reset clip");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(dly_a), 0, "reset taps");
    check("R8", int'(busy_b), 0, "inverted reset busy");

    repeat (3) step(1'b1, 1'b0);
    repeat (5) step(1'b0, 1'b0);           // goes negative: R7 wrap
    step(1'b1, 1'b1);                      // R6 enable held through busy
    step(1'b0, 1'b1);
    while (model_p < LIM) step(1'b1, 1'b0);
    step(1'b1, 1'b0);                      // R5 clip at top
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    while (model_p > -LIM) step(1'b0, 1'b0);
    step(1'b0, 1'b0);                      // R5 clip at bottom
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);

    repeat (LAT + 3) @(negedge clk);
    check("R3", sbq.size(), 0, "queue drained");
    check("R4", int'(set_a), -LIM + 1, "final setting");
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++; fails++;
      $display("FAIL R3 watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule